// File: doc/BRIEF.md
# 64-bit Shift and Rotate Execution Unit

This unit computes one shift or rotate of a 64-bit operand per strobe and returns the result, six status flag values and a per-flag write mask one clock later. It sits behind an integer issue stage. The issue stage provides the operand, a count, the current carry flag and an operation code. The retire logic uses the mask to decide which architectural flags to update. Operand fetch, memory read-modify-write, decoding and the choice of count source are done elsewhere.

Seven operations are supported: logical left shift, logical right shift, arithmetic right shift, rotate left, rotate right, rotate left through carry and rotate right through carry. Shifts update every flag. Plain rotates and carry rotates update only carry and overflow. The carry rotates treat the carry flag and the operand as a 65-bit ring. The count is still reduced to its low 6 bits, and it is not taken modulo 65.

Top module: `shrot_unit`

## Requirements
- R1: Only the low 6 bits of `in_cnt` form the effective count n (0 to 63). Bits 7:6 have no effect on any output.
- R2: When n is 0, `out_data` equals the operand, `out_wr_mask` is 6'b000000 and every flag output is 0.
- R3: Opcode 0, logical left: the result is operand shifted left by n. CF is operand bit 64-n. OF is CF XOR result bit 63.
- R4: Opcode 1, logical right: the result is operand shifted right by n with zero fill. CF is operand bit n-1. OF is result bit 63 XOR result bit 62.
- R5: Opcode 2, arithmetic right: the result is the operand shifted right by n with the sign bit copied in. CF is operand bit n-1. OF is always 0.
- R6: For opcodes 0 to 2 with n>0, the flags are set from the result: SF is result bit 63, ZF is 1 for a zero result, PF is 1 when result bits 7:0 hold an even number of ones, and AF is 0. The mask is 6'b111111.
- R7: Opcode 3, rotate left: CF is result bit 0 and OF is bit 0 XOR bit 63. Opcode 4, rotate right: CF is result bit 63 and OF is bit 63 XOR bit 62.
- R8: Opcodes 5 and 6 rotate the 65-bit ring {CF, operand} left or right by n. The new CF is the bit that lands in ring position 64. For opcode 5, OF is new CF XOR result bit 63. For opcode 6, OF is result bit 63 XOR bit 62.
- R9: For opcodes 3 to 6 with n>0, the mask is 6'b100001: only CF and OF are written.
- R10: Mask bit order is 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF. Any flag output whose mask bit is 0 reads 0.
- R11: The outputs register on the clock edge that samples `in_vld` high. `out_vld` is high for exactly that following cycle. While `in_vld` is low, `out_data`, the flags and the mask hold their values.
- R12: Opcode 7 is a no-op: `out_data` equals the operand and the mask is 0.
- R13: A synchronous active-high `rst` clears `out_vld`, `out_data`, all flags and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code 0..7 |
| in_cnt | input | 8 | Count; only bits 5:0 are used |
| in_data | input | 64 | Operand |
| in_cf | input | 1 | Incoming carry flag |
| out_vld | output | 1 | Result valid, one cycle after strobe |
| out_data | output | 64 | Result |
| out_of | output | 1 | Overflow flag value |
| out_cf | output | 1 | Carry flag value |
| out_sf | output | 1 | Sign flag value |
| out_zf | output | 1 | Zero flag value |
| out_pf | output | 1 | Parity flag value |
| out_af | output | 1 | Auxiliary carry flag value |
| out_wr_mask | output | 6 | Per-flag write enable |

## Verification
The assertions assume that `in_op`, `in_cnt`, `in_data` and `in_cf` are stable and known whenever `in_vld` is high. They also assume that reset is held for at least one clock before the first strobe. The stimulus changes inputs only on falling edges and drops the strobe for one cycle after every operation, so hold behaviour is seen after each result. The sweep visits every opcode, every effective count, both carry values and operands that stress the sign, zero and parity flags. The upper count bits vary across the sweep, which shows they have no effect.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_NOP = 3'd7
    } shrot_op_e;

    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_AF = 2;
    localparam int FL_ZF = 3;
    localparam int FL_SF = 4;
    localparam int FL_OF = 5;
    localparam int FL_N  = 6;
endpackage

// File: rtl/shrot_shifter.sv
module shrot_shifter
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [CNT_W-1:0]  cnt,
    input  shrot_op_e         op,
    output logic [DATA_W-1:0] res,
    output logic              cf,
    output logic              of
);
    logic [DATA_W:0] left_ext;
    logic [DATA_W:0] right_ext;
    logic [DATA_W:0] arith_ext;

    always_comb begin
        // extra bit catches the last bit shifted out
        left_ext  = {1'b0, opnd} << cnt;
        right_ext = {opnd, 1'b0} >> cnt;
        arith_ext = $signed({opnd, 1'b0}) >>> cnt;
        res = opnd;
        cf  = 1'b0;
        of  = 1'b0;
        case (op)
            OP_SHL: begin
                res = left_ext[DATA_W-1:0];
                cf  = left_ext[DATA_W];
                of  = left_ext[DATA_W] ^ left_ext[DATA_W-1];
            end
            OP_SHR: begin
                res = right_ext[DATA_W:1];
                cf  = right_ext[0];
                of  = right_ext[DATA_W] ^ right_ext[DATA_W-1];
            end
            OP_SAR: begin
                res = arith_ext[DATA_W:1];
                cf  = arith_ext[0];
                of  = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/shrot_rotator.sv
module shrot_rotator
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cf_in,
    input  shrot_op_e         op,
    output logic [DATA_W-1:0] res,
    output logic              cf,
    output logic              of
);
    localparam int RING_W = DATA_W + 1;

    logic [2*DATA_W-1:0] plain_l;
    logic [2*DATA_W-1:0] plain_r;
    logic [RING_W-1:0]   ring;
    logic [2*RING_W-1:0] ring_l;
    logic [2*RING_W-1:0] ring_r;

    always_comb begin
        // doubled copies turn a rotate into one shift
        plain_l = {opnd, opnd} << cnt;
        plain_r = {opnd, opnd} >> cnt;
        ring    = {cf_in, opnd};
        ring_l  = {ring, ring} << cnt;
        ring_r  = {ring, ring} >> cnt;
        res = opnd;
        cf  = 1'b0;
        of  = 1'b0;
        case (op)
            OP_ROL: begin
                res = plain_l[2*DATA_W-1:DATA_W];
                cf  = plain_l[DATA_W];
                of  = plain_l[DATA_W] ^ plain_l[2*DATA_W-1];
            end
            OP_ROR: begin
                res = plain_r[DATA_W-1:0];
                cf  = plain_r[DATA_W-1];
                of  = plain_r[DATA_W-1] ^ plain_r[DATA_W-2];
            end
            OP_RCL: begin
                res = ring_l[2*RING_W-2:RING_W];
                cf  = ring_l[2*RING_W-1];
                of  = ring_l[2*RING_W-1] ^ ring_l[2*RING_W-2];
            end
            OP_RCR: begin
                res = ring_r[DATA_W-1:0];
                cf  = ring_r[DATA_W];
                of  = ring_r[DATA_W-1] ^ ring_r[DATA_W-2];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int CNT_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [2:0]          in_op,
    input  logic [CNT_IN_W-1:0] in_cnt,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_cf,
    output logic                out_vld,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_of,
    output logic                out_cf,
    output logic                out_sf,
    output logic                out_zf,
    output logic                out_pf,
    output logic                out_af,
    output logic [FL_N-1:0]     out_wr_mask
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [FL_N-1:0]   flags;
        logic [FL_N-1:0]   mask;
    } shrot_state_t;

    shrot_state_t      st_d, st_q;
    shrot_op_e         op_e;
    logic [CNT_W-1:0]  eff_cnt;
    logic [DATA_W-1:0] sh_res, rt_res;
    logic              sh_cf, sh_of, rt_cf, rt_of;
    logic              is_shift, is_rot;

    assign op_e    = shrot_op_e'(in_op);
    assign eff_cnt = in_cnt[CNT_W-1:0];

    shrot_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shifter (
        .opnd (in_data),
        .cnt  (eff_cnt),
        .op   (op_e),
        .res  (sh_res),
        .cf   (sh_cf),
        .of   (sh_of)
    );

    shrot_rotator #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rotator (
        .opnd  (in_data),
        .cnt   (eff_cnt),
        .cf_in (in_cf),
        .op    (op_e),
        .res   (rt_res),
        .cf    (rt_cf),
        .of    (rt_of)
    );

    always_comb begin
        is_shift = (op_e == OP_SHL) || (op_e == OP_SHR) || (op_e == OP_SAR);
        is_rot   = (op_e == OP_ROL) || (op_e == OP_ROR) ||
                   (op_e == OP_RCL) || (op_e == OP_RCR);
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.data  = in_data;
            st_d.flags = '0;
            st_d.mask  = '0;
            if (eff_cnt != '0) begin
                if (is_shift) begin
                    st_d.data         = sh_res;
                    st_d.flags[FL_CF] = sh_cf;
                    st_d.flags[FL_OF] = sh_of;
                    st_d.flags[FL_SF] = sh_res[DATA_W-1];
                    st_d.flags[FL_ZF] = ~|sh_res;
                    st_d.flags[FL_PF] = ~^sh_res[7:0];
                    st_d.flags[FL_AF] = 1'b0;
                    st_d.mask         = '1;
                end else if (is_rot) begin
                    st_d.data         = rt_res;
                    st_d.flags[FL_CF] = rt_cf;
                    st_d.flags[FL_OF] = rt_of;
                    st_d.mask[FL_CF]  = 1'b1;
                    st_d.mask[FL_OF]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld     = st_q.vld;
    assign out_data    = st_q.data;
    assign out_cf      = st_q.flags[FL_CF];
    assign out_pf      = st_q.flags[FL_PF];
    assign out_af      = st_q.flags[FL_AF];
    assign out_zf      = st_q.flags[FL_ZF];
    assign out_sf      = st_q.flags[FL_SF];
    assign out_of      = st_q.flags[FL_OF];
    assign out_wr_mask = st_q.mask;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
    import shrot_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int CNT_IN_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_vld,
    input logic [2:0]          in_op,
    input logic [CNT_IN_W-1:0] in_cnt,
    input logic [DATA_W-1:0]   in_data,
    input logic                out_vld,
    input logic [DATA_W-1:0]   out_data,
    input logic                out_of,
    input logic                out_cf,
    input logic                out_sf,
    input logic                out_zf,
    input logic                out_pf,
    input logic                out_af,
    input logic [FL_N-1:0]     out_wr_mask
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [FL_N-1:0] flag_vec;
    logic            zero_cnt;
    logic            rot_op;
    assign flag_vec = {out_of, out_sf, out_zf, out_af, out_pf, out_cf};
    assign zero_cnt = (in_cnt[CNT_W-1:0] == '0);
    assign rot_op   = (in_op >= 3'd3) && (in_op <= 3'd6);

    // R11
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R11
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_data) && $stable(out_wr_mask) && $stable(flag_vec)));
    // R2
    zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && zero_cnt) |=> (out_wr_mask == '0 && out_data == $past(in_data)));
    // R9
    rot_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !zero_cnt && rot_op) |=> (out_wr_mask == 6'b100001));
    // R5
    sar_of_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !zero_cnt && in_op == 3'd2) |=> !out_of);
    // R12
    nop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == 3'd7) |=> (out_wr_mask == '0 && out_data == $past(in_data)));
    // R10
    unwritten_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_vec & ~out_wr_mask) == '0);
    // R6
    sign_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_wr_mask[FL_SF] |-> (out_sf == out_data[DATA_W-1] && out_zf == (out_data == '0)));
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_vld      (in_vld),
    .in_op       (in_op),
    .in_cnt      (in_cnt),
    .in_data     (in_data),
    .out_vld     (out_vld),
    .out_data    (out_data),
    .out_of      (out_of),
    .out_cf      (out_cf),
    .out_sf      (out_sf),
    .out_zf      (out_zf),
    .out_pf      (out_pf),
    .out_af      (out_af),
    .out_wr_mask (out_wr_mask)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [2:0]  in_op = '0;
    logic [7:0]  in_cnt = '0;
    logic [63:0] in_data = '0;
    logic        in_cf = 1'b0;
    logic        out_vld;
    logic [63:0] out_data;
    logic        out_of, out_cf, out_sf, out_zf, out_pf, out_af;
    logic [5:0]  out_wr_mask;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    shrot_unit u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .in_cnt(in_cnt),
        .in_data(in_data), .in_cf(in_cf), .out_vld(out_vld), .out_data(out_data),
        .out_of(out_of), .out_cf(out_cf), .out_sf(out_sf), .out_zf(out_zf),
        .out_pf(out_pf), .out_af(out_af), .out_wr_mask(out_wr_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] pattern(input int p);
        case (p)
            0: return 64'h0;
            1: return '1;
            2: return 64'h8000_0000_0000_0001;
            3: return 64'h0123_4567_89AB_CDEF;
            4: return 64'h7FFF_FFFF_FFFF_FFFE;
            default: return 64'hA5A5_5A5A_F00F_0FF1;
        endcase
    endfunction

    // bit-at-a-time reference model; flag order {OF,SF,ZF,AF,PF,CF}
    task automatic model(input logic [2:0] op, input logic [7:0] cnt, input logic [63:0] a,
                         input logic c_in, output logic [63:0] r, output logic [5:0] fl,
                         output logic [5:0] mk);
        int n;
        logic c, t;
        n = int'(cnt[5:0]);
        r = a; fl = '0; mk = '0; c = c_in;
        if (n == 0 || op == 3'd7) return;
        for (int i = 0; i < n; i++) begin
            case (op)
                3'd0: begin c = r[63]; r = {r[62:0], 1'b0}; end
                3'd1: begin c = r[0];  r = {1'b0, r[63:1]}; end
                3'd2: begin c = r[0];  r = {r[63], r[63:1]}; end
                3'd3: begin r = {r[62:0], r[63]}; c = r[0]; end
                3'd4: begin r = {r[0], r[63:1]}; c = r[63]; end
                3'd5: begin t = r[63]; r = {r[62:0], c}; c = t; end
                default: begin t = r[0]; r = {c, r[63:1]}; c = t; end
            endcase
        end
        fl[0] = c;
        case (op)
            3'd0, 3'd5: fl[5] = c ^ r[63];
            3'd2:       fl[5] = 1'b0;
            3'd3:       fl[5] = r[0] ^ r[63];
            default:    fl[5] = r[62] ^ r[63];
        endcase
        if (op <= 3'd2) begin
            fl[4] = r[63];
            fl[3] = (r == 64'd0);
            fl[2] = 1'b0;
            fl[1] = ~^r[7:0];
            mk = 6'b111111;
        end else begin
            mk = 6'b100001;
        end
    endtask

    function automatic string tag(input logic [2:0] op, input logic [7:0] cnt);
        string s;
        if (cnt[5:0] == 0)     s = "R2";
        else case (op)
            3'd0: s = "R3 R6";
            3'd1: s = "R4 R6";
            3'd2: s = "R5 R6";
            3'd3, 3'd4: s = "R7 R9";
            3'd5, 3'd6: s = "R8 R9";
            default: s = "R12";
        endcase
        if (cnt[7:6] != 0) s = {s, " R1"};
        return {s, " R10"};
    endfunction

    task automatic check(input string req, input logic [75:0] act, input logic [75:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [7:0] cnt,
                          input logic [63:0] a, input logic c);
        logic [63:0] r;
        logic [5:0]  fl, mk;
        logic [75:0] held;
        model(op, cnt, a, c, r, fl, mk);
        @(negedge clk);
        in_vld = 1'b1; in_op = op; in_cnt = cnt; in_data = a; in_cf = c;
        @(negedge clk);
        in_vld = 1'b0;
        check(tag(op, cnt),
              {out_data, out_of, out_sf, out_zf, out_af, out_pf, out_cf, out_wr_mask},
              {r, fl, mk});
        check("R11 valid pulse", {75'd0, out_vld}, {75'd0, 1'b1});
        held = {out_data, out_of, out_sf, out_zf, out_af, out_pf, out_cf, out_wr_mask};
        // scramble idle inputs: must not matter while strobe is low
        in_data = ~a; in_op = op + 3'd1; in_cnt = cnt + 8'd1;
        @(negedge clk);
        check("R11 hold",
              {out_vld, out_data, out_of, out_sf, out_zf, out_af, out_pf, out_cf, out_wr_mask},
              {1'b0, held});
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                done = 1'b1;
                $finish;
            end
        end
    end

    initial begin
        // R13: drive a strobe during reset; outputs must stay cleared
        in_vld = 1'b1; in_op = 3'd0; in_cnt = 8'd3; in_data = '1; in_cf = 1'b1;
        repeat (3) @(negedge clk);
        check("R13 reset state",
              {out_data, out_of, out_sf, out_zf, out_af, out_pf, out_cf, out_wr_mask},
              76'd0);
        check("R13 reset valid", {75'd0, out_vld}, 76'd0);
        in_vld = 1'b0;
        rst = 1'b0;
        // directed corner: carry rotate by 1 puts old CF at the ring edge (R8)
        run_op(3'd5, 8'd1, 64'h8000_0000_0000_0000, 1'b1);
        run_op(3'd6, 8'd1, 64'h0000_0000_0000_0001, 1'b1);
        for (int op = 0; op < 8; op++)
            for (int n = 0; n < 64; n++)
                for (int p = 0; p < 6; p++)
                    for (int c = 0; c < 2; c++)
                        run_op(3'(op), {2'((p + op + c) % 4), 6'(n)}, pattern(p), 1'(c));
        // R1: count 64 masks to 0, count 65 acts as 1
        run_op(3'd0, 8'd64, 64'h1234, 1'b0);
        run_op(3'd0, 8'd65, 64'h1234, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule